// File: doc/BRIEF.md
# Cache Invalidation Cycle Controller

This block sits inside a bus-master peripheral on a 486-style local bus. It decides when the peripheral raises its invalidation strobe towards the host cache, and which upper address lines it releases while the host holds the address bus. It also cleans up the writeback input. A small configuration store holds two fields. The first is a 5-bit line length code that selects how many low address bits stay driven during address hold. The second is one control bit whose meaning depends on the bus mode.

In 486 mode with the control bit set, the block raises the invalidation strobe for the peripheral's own master cycles only. Cycles run by other masters are not snooped. In local-bus (VL) mode, the strobe follows every address strobe. In that mode the control bit instead forces the qualified writeback high. VL mode also overrides the stored line length: the float logic then behaves as if the code were 00001. The float mask is captured once, on the edge where address hold is first seen high. It is presented only while hold stays asserted.

Top module: `cic_ctrl`

## Requirements
- R1: After hard reset (rst_n low) the line length code is 00100 and the control bit is 0: float_mask and inval_strobe read 0, and the first address hold in 486 mode floats bits 31..4 (mask 0xFFFFFFF0).
- R2: The stored line length code and control bit change only on a clock edge with cfg_we high; with cfg_we low, cfg_len_in and cfg_ctl_in have no effect on later masks.
- R3: In 486 mode (bus_vl=0) the captured mask is: 00000 -> 0x00000000, 00001 -> 0xFFFFFFFC, 00010 -> 0xFFFFFFF8, 00100 -> 0xFFFFFFF0, 01000 -> 0xFFFFFFE0, 10000 -> 0xFFFFFFC0.
- R4: With bus_vl=1 the mask is 0xFFFFFFFC and cfg_err is 0, whatever code is stored.
- R5: With bus_vl=1, inval_strobe equals addr_strobe in the same cycle, regardless of the control bit and own_access.
- R6: With bus_vl=0, inval_strobe = addr_strobe & own_access when the control bit is 1, and is 0 when it is 0.
- R7: wrback_q is 1 when bus_vl=1 and the control bit is 1; otherwise wrback_q equals wrback_in.
- R8: In 486 mode a stored code with more than one bit set is reserved: cfg_err is 1 in that cycle, and a mask captured from it is 0.
- R9: float_mask is captured on the edge where addr_hold is first sampled high. It is held unchanged while addr_hold stays high, even across configuration writes. It reads 0 from the edge after which addr_hold is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_len_in | input | 5 | Line length code to store |
| cfg_ctl_in | input | 1 | Control bit to store |
| bus_vl | input | 1 | 1 = VL mode, 0 = 486 mode |
| addr_strobe | input | 1 | Address strobe, active high |
| own_access | input | 1 | Current cycle is run by this peripheral |
| wrback_in | input | 1 | Raw writeback input |
| addr_hold | input | 1 | Host address hold request |
| inval_strobe | output | 1 | Invalidation strobe towards the host cache |
| float_mask | output | 32 | 1 = address bit released |
| wrback_q | output | 1 | Qualified writeback |
| cfg_err | output | 1 | Effective line length code is reserved |

## Verification
The bench changes the stored code while address hold is high. A design that re-decodes the mask every cycle, instead of capturing it at the rising edge of hold, would then change the released lines in the middle of a hold. It checks VL mode against stored codes that are reserved and that select a wide float. A design that forgets the override would float the wrong lines or flag an error. In 486 mode it drives address strobes from other masters. A design that snoops them would raise the strobe for cycles it must ignore. Random mixes of mode, control bit and writeback find any design that lets the control bit force writeback in 486 mode.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int ADDR_W_DEF   = 32;
  localparam int LEN_W_DEF    = 5;
  localparam int BASE_BIT_DEF = 2;

  typedef enum logic {
    BUS_486 = 1'b0,
    BUS_VL  = 1'b1
  } bus_mode_e;

  typedef struct packed {
    logic inval_en;
    logic vl_wb_force;
  } ctl_view_t;
endpackage

// File: rtl/cic_cfg_reg.sv
module cic_cfg_reg #(
  parameter int           LEN_W     = 5,
  parameter logic [LEN_W-1:0] RESET_LEN = 5'b00100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LEN_W-1:0] len_in,
  input  logic             ctl_in,
  output logic [LEN_W-1:0] len_q,
  output logic             ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= RESET_LEN;
      ctl_q <= 1'b0;
    end else if (we) begin
      len_q <= len_in;
      ctl_q <= ctl_in;
    end
  end
endmodule

// File: rtl/cic_len_sel.sv
module cic_len_sel
  import cic_pkg::*;
#(
  parameter int               LEN_W  = 5,
  parameter logic [LEN_W-1:0] VL_LEN = 5'b00001
) (
  input  bus_mode_e        mode,
  input  logic [LEN_W-1:0] stored_len,
  output logic [LEN_W-1:0] eff_len,
  output logic             legal
);
  function automatic logic code_legal(input logic [LEN_W-1:0] code);
    return $countones(code) <= 1;
  endfunction

  always_comb begin
    eff_len = (mode == BUS_VL) ? VL_LEN : stored_len;
    legal   = code_legal(eff_len);
  end
endmodule

// File: rtl/cic_float_map.sv
module cic_float_map #(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 5,
  parameter int BASE_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [LEN_W-1:0]  eff_len,
  input  logic              legal,
  output logic              hold_rise,
  output logic              hold_d,
  output logic [ADDR_W-1:0] mask
);
  logic [ADDR_W-1:0] mask_q;

  function automatic logic [ADDR_W-1:0] decode_float(input logic [LEN_W-1:0] code);
    logic [ADDR_W-1:0] m;
    m = '0;
    for (int i = 0; i < LEN_W; i++) begin
      if (code == (LEN_W'(1) << i)) m = {ADDR_W{1'b1}} << (BASE_BIT + i);
    end
    return m;
  endfunction

  assign hold_rise = hold && !hold_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_d <= 1'b0;
      mask_q <= '0;
    end else begin
      hold_d <= hold;
      if (hold_rise) mask_q <= legal ? decode_float(eff_len) : '0;
    end
  end

  assign mask = hold_d ? mask_q : '0;
endmodule

// File: rtl/cic_strobe_qual.sv
module cic_strobe_qual
  import cic_pkg::*;
(
  input  bus_mode_e mode,
  input  logic      ctl,
  input  logic      strobe,
  input  logic      own,
  input  logic      wb_raw,
  output logic      inval,
  output logic      wb_out
);
  ctl_view_t view;

  always_comb begin
    view.inval_en    = (mode == BUS_486) && ctl;
    view.vl_wb_force = (mode == BUS_VL) && ctl;
    if (mode == BUS_VL) inval = strobe;
    else                inval = strobe && own && view.inval_en;
    wb_out = view.vl_wb_force ? 1'b1 : wb_raw;
  end
endmodule

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
#(
  parameter int               ADDR_W    = ADDR_W_DEF,
  parameter int               LEN_W     = LEN_W_DEF,
  parameter int               BASE_BIT  = BASE_BIT_DEF,
  parameter logic [LEN_W-1:0] RESET_LEN = 5'b00100,
  parameter logic [LEN_W-1:0] VL_LEN    = 5'b00001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [LEN_W-1:0]  cfg_len_in,
  input  logic              cfg_ctl_in,
  input  logic              bus_vl,
  input  logic              addr_strobe,
  input  logic              own_access,
  input  logic              wrback_in,
  input  logic              addr_hold,
  output logic              inval_strobe,
  output logic [ADDR_W-1:0] float_mask,
  output logic              wrback_q,
  output logic              cfg_err
);
  bus_mode_e        mode;
  logic [LEN_W-1:0] len_q;
  logic             ctl_q;
  logic [LEN_W-1:0] eff_len;
  logic             len_legal;
  logic             hold_rise;
  logic             hold_d;

  assign mode = bus_vl ? BUS_VL : BUS_486;

  cic_cfg_reg #(.LEN_W(LEN_W), .RESET_LEN(RESET_LEN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .len_in(cfg_len_in),
    .ctl_in(cfg_ctl_in), .len_q(len_q), .ctl_q(ctl_q)
  );

  cic_len_sel #(.LEN_W(LEN_W), .VL_LEN(VL_LEN)) u_sel (
    .mode(mode), .stored_len(len_q), .eff_len(eff_len), .legal(len_legal)
  );

  cic_float_map #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BASE_BIT(BASE_BIT)) u_map (
    .clk(clk), .rst_n(rst_n), .hold(addr_hold), .eff_len(eff_len),
    .legal(len_legal), .hold_rise(hold_rise), .hold_d(hold_d), .mask(float_mask)
  );

  cic_strobe_qual u_qual (
    .mode(mode), .ctl(ctl_q), .strobe(addr_strobe), .own(own_access),
    .wb_raw(wrback_in), .inval(inval_strobe), .wb_out(wrback_q)
  );

  assign cfg_err = !len_legal;
endmodule

// File: rtl/cic_ctrl_chk.sv
module cic_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              bus_vl,
  input logic              addr_strobe,
  input logic              own_access,
  input logic              addr_hold,
  input logic              inval_strobe,
  input logic [ADDR_W-1:0] float_mask,
  input logic              wrback_q,
  input logic              cfg_err,
  input logic [LEN_W-1:0]  len_q,
  input logic              ctl_q,
  input logic              hold_rise
);
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(len_q) && $stable(ctl_q))); // R2
  AST_VL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vl |-> !cfg_err); // R4
  AST_VL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vl |-> (inval_strobe == addr_strobe)); // R5
  AST_NO_FOREIGN_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_vl && !own_access) |-> !inval_strobe); // R6
  AST_WB_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vl && ctl_q) |-> wrback_q); // R7
  AST_RESERVED_NO_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_rise && cfg_err) |=> (float_mask == '0)); // R8
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hold && !hold_rise) |=> $stable(float_mask)); // R9
  AST_IDLE_NO_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(addr_hold) |-> (float_mask == '0)); // R9
endmodule

bind cic_ctrl cic_ctrl_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .bus_vl(bus_vl),
  .addr_strobe(addr_strobe), .own_access(own_access), .addr_hold(addr_hold),
  .inval_strobe(inval_strobe), .float_mask(float_mask), .wrback_q(wrback_q),
  .cfg_err(cfg_err), .len_q(len_q), .ctl_q(ctl_q), .hold_rise(hold_rise)
);

// File: tb/cic_ctrl_tb.sv
module cic_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_ctl_in, bus_vl, addr_strobe, own_access, wrback_in, addr_hold;
  logic [4:0]  cfg_len_in;
  logic        inval_strobe, wrback_q, cfg_err;
  logic [31:0] float_mask;

  int n_chk = 0;
  int n_err = 0;

  logic [4:0]  m_len;
  logic        m_ctl, m_hold;
  logic [31:0] m_mask;

  always #10 clk = ~clk;

  cic_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len_in(cfg_len_in),
    .cfg_ctl_in(cfg_ctl_in), .bus_vl(bus_vl), .addr_strobe(addr_strobe),
    .own_access(own_access), .wrback_in(wrback_in), .addr_hold(addr_hold),
    .inval_strobe(inval_strobe), .float_mask(float_mask), .wrback_q(wrback_q),
    .cfg_err(cfg_err)
  );

  function automatic logic [31:0] exp_mask(input logic [4:0] len, input logic vl);
    logic [4:0] e;
    e = vl ? 5'b00001 : len;
    case (e)
      5'b00001: return 32'hFFFF_FFFC;
      5'b00010: return 32'hFFFF_FFF8;
      5'b00100: return 32'hFFFF_FFF0;
      5'b01000: return 32'hFFFF_FFE0;
      5'b10000: return 32'hFFFF_FFC0;
      default:  return 32'h0;
    endcase
  endfunction

  function automatic logic exp_err(input logic [4:0] len, input logic vl);
    if (vl) return 1'b0;
    return !(len inside {5'b00000, 5'b00001, 5'b00010, 5'b00100, 5'b01000, 5'b10000});
  endfunction

  function automatic logic exp_inval(input logic vl, input logic ctl, input logic s, input logic own);
    if (vl) return s;
    return ctl & s & own;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [4:0] len, input logic ctl, input logic vl,
                     input logic s, input logic own, input logic wb, input logic ah);
    cfg_we = we; cfg_len_in = len; cfg_ctl_in = ctl; bus_vl = vl;
    addr_strobe = s; own_access = own; wrback_in = wb; addr_hold = ah;
    #2;
    chk(vl ? "R5 strobe" : "R6 strobe", 32'(inval_strobe), 32'(exp_inval(vl, m_ctl, s, own)));
    chk("R7 writeback", 32'(wrback_q), 32'((vl && m_ctl) ? 1'b1 : wb));
    chk("R8 error flag", 32'(cfg_err), 32'(exp_err(m_len, vl)));
    chk("R3 mask", float_mask, m_mask);
    @(posedge clk);
    if (ah && !m_hold) m_mask = exp_mask(m_len, vl);
    else if (!ah) m_mask = 32'h0;
    m_hold = ah;
    if (we) begin m_len = len; m_ctl = ctl; end
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [4:0] legal_codes [6];
    legal_codes = '{5'b00000, 5'b00001, 5'b00010, 5'b00100, 5'b01000, 5'b10000};
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    cfg_we = 0; cfg_len_in = 0; cfg_ctl_in = 0; bus_vl = 0;
    addr_strobe = 1; own_access = 1; wrback_in = 0; addr_hold = 1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset mask", float_mask, 32'h0);
    chk("R1 reset strobe", 32'(inval_strobe), 32'h0);
    addr_hold = 0;
    rst_n = 1'b1;
    m_len = 5'b00100; m_ctl = 0; m_hold = 0; m_mask = 0;
    @(negedge clk); #1;

    // R1: default code floats bits 31..4
    cyc(0, 5'b0, 0, 0, 0, 0, 0, 1);
    chk("R1 default mask", float_mask, 32'hFFFF_FFF0);
    // R9: write during hold does not disturb the captured mask
    cyc(1, 5'b00001, 1, 0, 1, 1, 0, 1);
    cyc(0, 5'b0, 0, 0, 0, 0, 0, 1);
    chk("R9 held mask", float_mask, 32'hFFFF_FFF0);
    cyc(0, 5'b0, 0, 0, 0, 0, 0, 0);
    chk("R9 release", float_mask, 32'h0);
    // R2: inputs ignored without write enable
    cyc(0, 5'b10000, 0, 0, 1, 1, 0, 0);
    cyc(0, 5'b10000, 0, 0, 1, 1, 0, 1);
    chk("R2 code kept", float_mask, 32'hFFFF_FFFC);
    cyc(0, 5'b0, 0, 0, 1, 1, 0, 0);
    chk("R2 ctl kept", 32'(inval_strobe), 32'h1);
    // R4: VL overrides wide code
    cyc(1, 5'b10000, 1, 0, 0, 0, 0, 0);
    cyc(0, 5'b0, 0, 1, 1, 0, 0, 1);
    chk("R4 vl mask", float_mask, 32'hFFFF_FFFC);
    chk("R7 vl force", 32'(wrback_q), 32'h1);
    cyc(0, 5'b0, 0, 0, 0, 0, 0, 0);
    cyc(0, 5'b0, 0, 0, 0, 0, 0, 1);
    chk("R3 wide mask", float_mask, 32'hFFFF_FFC0);
    cyc(0, 5'b0, 0, 0, 0, 0, 0, 0);
    // R8: reserved code
    cyc(1, 5'b00011, 0, 0, 0, 0, 0, 0);
    chk("R8 err", 32'(cfg_err), 32'h1);
    bus_vl = 1; #1;
    chk("R4 vl no err", 32'(cfg_err), 32'h0);
    cyc(0, 5'b0, 0, 0, 0, 0, 0, 1);
    chk("R8 no float", float_mask, 32'h0);
    cyc(0, 5'b0, 0, 0, 0, 0, 0, 0);

    for (int k = 0; k < 4000; k++) begin
      logic [4:0] len;
      len = ($urandom_range(0, 9) < 7) ? legal_codes[$urandom_range(0, 5)] : 5'($urandom);
      cyc(($urandom_range(0, 7) == 0), len, 1'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom), ($urandom_range(0, 3) != 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule